// File: doc/BRIEF.md
# Lockable FIFO Configuration Register

This block stores the FIFO settings of a storage controller: an enable bit, a 4-bit FIFO threshold and an 8-bit track number at which write precompensation starts. A configure-write port loads all three fields at once. A lock-command port writes a separate lock bit. On the following cycle it produces a one-byte status that reports the new lock value.

The lock bit sets what a software reset does to the three fields. When the lock is clear, a software reset returns the fields to their defaults. When the lock is set, the fields keep the values last programmed. A software reset never changes the lock bit. Only the asynchronous hardware reset clears it. The hardware reset also restores the fields, whatever the lock state.

Top module: `lockable_cfg_reg`

## Requirements
- R1: While hardware reset is active, and after its synchronised release, the outputs are as follows: fifo_en is 0, fifo_thr is 0, precomp_trk is 0, lock_q is 0 and stat_vld is 0.
- R2: A cycle with cfg_we high loads cfg_en_i, cfg_thr_i and cfg_trk_i into fifo_en, fifo_thr and precomp_trk, visible after that clock edge, whatever the lock state.
- R3: A cycle with lock_we high writes lock_val_i into lock_q, visible after that clock edge.
- R4: In the cycle after a lock command, stat_vld is 1 for exactly one cycle. In that cycle, stat_byte holds the new lock value at bit 4 and 0 in every other bit, so it reads 8'h10 when locked and 8'h00 when unlocked.
- R5: When the previous cycle had no lock command, stat_vld is 0 and stat_byte is 8'h00.
- R6: A sw_rst cycle while lock_q is 0 returns all three fields to their defaults (disabled, threshold 0, track 0).
- R7: A sw_rst cycle while lock_q is 1 leaves all three fields unchanged.
- R8: sw_rst never changes lock_q.
- R9: When sw_rst and cfg_we occur in the same cycle, the defaults win if lock_q is 0, and the written values are loaded if lock_q is 1.
- R10: A software reset is decided by the lock_q value held before that cycle's edge. A lock command in the same cycle does not change the outcome for the fields, but it still updates lock_q.
- R11: Asserting the hardware reset in the middle of operation immediately clears lock_q and restores the field defaults, even while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| sw_rst | input | 1 | Software reset request, one cycle per request |
| cfg_we | input | 1 | Configure write strobe |
| cfg_en_i | input | 1 | FIFO enable value to write |
| cfg_thr_i | input | 4 | FIFO threshold value to write |
| cfg_trk_i | input | 8 | Precompensation start track to write |
| lock_we | input | 1 | Lock command strobe |
| lock_val_i | input | 1 | Lock value carried by the command |
| fifo_en | output | 1 | Current FIFO enable |
| fifo_thr | output | 4 | Current FIFO threshold |
| precomp_trk | output | 8 | Current precompensation start track |
| lock_q | output | 1 | Current lock bit |
| stat_vld | output | 1 | Status byte valid, one-cycle pulse |
| stat_byte | output | 8 | Status byte after a lock command |

## Verification
The hardest cases to reach are those where a software reset meets another write in the same cycle. With a configure write, the lock decides which one wins. With a lock command that flips the lock, the fields must follow the old lock while the lock bit takes the new value. The bench first puts the lock into a known state and programs fields that are not at their defaults. It then drives both strobes in one cycle, with the lock both clear and set and in both flip directions, and reads the fields and the lock afterwards. A hardware reset is also asserted partway through a clock period while the block is locked, and the outputs are checked before the next edge.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int THR_W = 4;
  localparam int TRK_W = 8;

  typedef struct packed {
    logic             en;
    logic [THR_W-1:0] thr;
    logic [TRK_W-1:0] trk;
  } cfg_t;

  localparam cfg_t CFG_DFLT = '{en: 1'b0, thr: '0, trk: '0};
endpackage

// File: rtl/lcr_rst_sync.sv
module lcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lcr_fields.sv
module lcr_fields
  import lcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic lock_cur,
  input  logic wr_en,
  input  cfg_t wr_val,
  output cfg_t cfg_q
);
  cfg_t cfg_d;
  logic cfg_ce;

  // Software reset (unlocked) outranks a configure write.
  always_comb begin
    cfg_d  = cfg_q;
    cfg_ce = 1'b0;
    if (sw_rst && !lock_cur) begin
      cfg_d  = CFG_DFLT;
      cfg_ce = 1'b1;
    end else if (wr_en) begin
      cfg_d  = wr_val;
      cfg_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_DFLT;
    else if (cfg_ce) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/lcr_lock_stat.sv
module lcr_lock_stat #(
  parameter int STAT_W   = 8,
  parameter int LOCK_POS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              cmd_val,
  output logic              lock_q,
  output logic              vld_q,
  output logic [STAT_W-1:0] byte_q
);
  logic              lock_d;
  logic [STAT_W-1:0] byte_d;

  always_comb begin
    lock_d = cmd_we ? cmd_val : lock_q;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == LOCK_POS) begin : g_lock
      assign byte_d[b] = cmd_we & cmd_val;
    end else begin : g_zero
      assign byte_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= 1'b0;
    else if (cmd_we) lock_q <= lock_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q  <= cmd_we;
      byte_q <= byte_d;
    end
  end
endmodule

// File: rtl/lockable_cfg_reg.sv
module lockable_cfg_reg
  import lcr_pkg::*;
#(
  parameter int STAT_W      = 8,
  parameter int LOCK_POS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              cfg_we,
  input  logic              cfg_en_i,
  input  logic [THR_W-1:0]  cfg_thr_i,
  input  logic [TRK_W-1:0]  cfg_trk_i,
  input  logic              lock_we,
  input  logic              lock_val_i,
  output logic              fifo_en,
  output logic [THR_W-1:0]  fifo_thr,
  output logic [TRK_W-1:0]  precomp_trk,
  output logic              lock_q,
  output logic              stat_vld,
  output logic [STAT_W-1:0] stat_byte
);
  logic hw_rst_n;
  cfg_t wr_val;
  cfg_t cfg_cur;

  lcr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (hw_rst_n)
  );

  assign wr_val = '{en: cfg_en_i, thr: cfg_thr_i, trk: cfg_trk_i};

  lcr_fields u_fields (
    .clk      (clk),
    .rst_n    (hw_rst_n),
    .sw_rst   (sw_rst),
    .lock_cur (lock_q),
    .wr_en    (cfg_we),
    .wr_val   (wr_val),
    .cfg_q    (cfg_cur)
  );

  lcr_lock_stat #(.STAT_W(STAT_W), .LOCK_POS(LOCK_POS)) u_lock (
    .clk     (clk),
    .rst_n   (hw_rst_n),
    .cmd_we  (lock_we),
    .cmd_val (lock_val_i),
    .lock_q  (lock_q),
    .vld_q   (stat_vld),
    .byte_q  (stat_byte)
  );

  assign fifo_en     = cfg_cur.en;
  assign fifo_thr    = cfg_cur.thr;
  assign precomp_trk = cfg_cur.trk;
endmodule

// File: rtl/lockable_cfg_reg_chk.sv
module lockable_cfg_reg_chk
  import lcr_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int LOCK_POS = 4
) (
  input logic              clk,
  input logic              hw_rst_n,
  input logic              sw_rst,
  input logic              cfg_we,
  input logic              cfg_en_i,
  input logic [THR_W-1:0]  cfg_thr_i,
  input logic [TRK_W-1:0]  cfg_trk_i,
  input logic              lock_we,
  input logic              lock_val_i,
  input logic              fifo_en,
  input logic [THR_W-1:0]  fifo_thr,
  input logic [TRK_W-1:0]  precomp_trk,
  input logic              lock_q,
  input logic              stat_vld,
  input logic [STAT_W-1:0] stat_byte
);
  // R1
  hw_dflt_chk: assert property (@(posedge clk)
    !hw_rst_n |-> (!fifo_en && fifo_thr == '0 && precomp_trk == '0 && !lock_q && !stat_vld));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (cfg_we && !(sw_rst && !lock_q)) |=>
      (fifo_en == $past(cfg_en_i) && fifo_thr == $past(cfg_thr_i) && precomp_trk == $past(cfg_trk_i)));

  // R3
  lock_wr_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    lock_we |=> (lock_q == $past(lock_val_i)));

  // R4
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    lock_we |=> (stat_vld && stat_byte == (STAT_W'($past(lock_val_i)) << LOCK_POS)));

  // R5
  stat_idle_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !lock_we |=> (!stat_vld && stat_byte == '0));

  // R6
  sw_dflt_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && !lock_q) |=> (!fifo_en && fifo_thr == '0 && precomp_trk == '0));

  // R7
  sw_hold_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && lock_q && !cfg_we) |=> ($stable(fifo_en) && $stable(fifo_thr) && $stable(precomp_trk)));

  // R8
  sw_lock_keep_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && !lock_we) |=> $stable(lock_q));
endmodule

bind lockable_cfg_reg lockable_cfg_reg_chk #(.STAT_W(STAT_W), .LOCK_POS(LOCK_POS)) u_chk (
  .clk         (clk),
  .hw_rst_n    (hw_rst_n),
  .sw_rst      (sw_rst),
  .cfg_we      (cfg_we),
  .cfg_en_i    (cfg_en_i),
  .cfg_thr_i   (cfg_thr_i),
  .cfg_trk_i   (cfg_trk_i),
  .lock_we     (lock_we),
  .lock_val_i  (lock_val_i),
  .fifo_en     (fifo_en),
  .fifo_thr    (fifo_thr),
  .precomp_trk (precomp_trk),
  .lock_q      (lock_q),
  .stat_vld    (stat_vld),
  .stat_byte   (stat_byte)
);

// File: tb/sim_lockable_cfg_reg.sv
module sim_lockable_cfg_reg;
  logic       clk;
  logic       rst_n;
  logic       sw_rst;
  logic       cfg_we;
  logic       cfg_en_i;
  logic [3:0] cfg_thr_i;
  logic [7:0] cfg_trk_i;
  logic       lock_we;
  logic       lock_val_i;
  logic       fifo_en;
  logic [3:0] fifo_thr;
  logic [7:0] precomp_trk;
  logic       lock_q;
  logic       stat_vld;
  logic [7:0] stat_byte;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  lockable_cfg_reg u0 (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we),
    .cfg_en_i(cfg_en_i), .cfg_thr_i(cfg_thr_i), .cfg_trk_i(cfg_trk_i),
    .lock_we(lock_we), .lock_val_i(lock_val_i),
    .fifo_en(fifo_en), .fifo_thr(fifo_thr), .precomp_trk(precomp_trk),
    .lock_q(lock_q), .stat_vld(stat_vld), .stat_byte(stat_byte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_cfg(input string rq, input bit en, input int thr, input int trk);
    chk(rq, "fifo_en", int'(fifo_en), int'(en));
    chk(rq, "fifo_thr", int'(fifo_thr), thr);
    chk(rq, "precomp_trk", int'(precomp_trk), trk);
  endtask

  task automatic idle();
    sw_rst = 0; cfg_we = 0; cfg_en_i = 0; cfg_thr_i = 0; cfg_trk_i = 0;
    lock_we = 0; lock_val_i = 0;
  endtask

  // Drive one cycle of stimulus at the falling edge, sample just after the rising edge.
  task automatic cycle(input bit s, input bit w, input bit en, input int thr, input int trk,
                       input bit l, input bit lv);
    @(negedge clk);
    sw_rst = s; cfg_we = w; cfg_en_i = en; cfg_thr_i = 4'(thr); cfg_trk_i = 8'(trk);
    lock_we = l; lock_val_i = lv;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic do_hw_reset();
    @(negedge clk);
    rst_n = 0;
    #3;
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk_cfg("R1", 0, 0, 0);
    chk("R1", "lock_q", int'(lock_q), 0);
    chk("R1", "stat_vld", int'(stat_vld), 0);
  endtask

  task automatic t_cfg_write();
    cycle(0, 1, 1, 9, 'hA5, 0, 0);
    chk_cfg("R2", 1, 9, 'hA5);
    cycle(0, 1, 0, 'hF, 'h3C, 0, 0);
    chk_cfg("R2", 0, 'hF, 'h3C);
  endtask

  task automatic t_lock();
    cycle(0, 0, 0, 0, 0, 1, 1);
    chk("R3", "lock_q", int'(lock_q), 1);
    chk("R4", "stat_vld", int'(stat_vld), 1);
    chk("R4", "stat_byte", int'(stat_byte), 'h10);
    cycle(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "stat_vld", int'(stat_vld), 0);
    chk("R5", "stat_byte", int'(stat_byte), 0);
    cycle(0, 1, 1, 3, 'h77, 0, 0);
    chk_cfg("R2", 1, 3, 'h77);
    cycle(0, 0, 0, 0, 0, 1, 0);
    chk("R3", "lock_q", int'(lock_q), 0);
    chk("R4", "stat_vld", int'(stat_vld), 1);
    chk("R4", "stat_byte", int'(stat_byte), 0);
  endtask

  task automatic t_sw_unlocked();
    cycle(0, 1, 1, 6, 'h42, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, 0);
    chk_cfg("R6", 0, 0, 0);
    chk("R8", "lock_q", int'(lock_q), 0);
  endtask

  task automatic t_sw_locked();
    cycle(0, 0, 0, 0, 0, 1, 1);
    cycle(0, 1, 1, 'hC, 'h9E, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, 0);
    chk_cfg("R7", 1, 'hC, 'h9E);
    chk("R8", "lock_q", int'(lock_q), 1);
    chk("R5", "stat_vld", int'(stat_vld), 0);
  endtask

  task automatic t_same_cycle();
    // lock is 1 on entry
    cycle(1, 1, 0, 5, 'h11, 0, 0);
    chk_cfg("R9", 0, 5, 'h11);
    cycle(0, 0, 0, 0, 0, 1, 0);
    cycle(0, 1, 1, 7, 'h88, 0, 0);
    cycle(1, 1, 1, 2, 'h22, 0, 0);
    chk_cfg("R9", 0, 0, 0);
  endtask

  task automatic t_order();
    // lock is 0 on entry
    cycle(0, 1, 1, 4, 'h5A, 0, 0);
    cycle(1, 0, 0, 0, 0, 1, 1);
    chk_cfg("R10", 0, 0, 0);
    chk("R10", "lock_q", int'(lock_q), 1);
    cycle(0, 1, 1, 8, 'hC3, 0, 0);
    cycle(1, 0, 0, 0, 0, 1, 0);
    chk_cfg("R10", 1, 8, 'hC3);
    chk("R10", "lock_q", int'(lock_q), 0);
  endtask

  task automatic t_hw_mid();
    cycle(0, 0, 0, 0, 0, 1, 1);
    cycle(0, 1, 1, 'hE, 'hF0, 0, 0);
    @(negedge clk);
    #2;
    rst_n = 0;
    #1;
    chk_cfg("R11", 0, 0, 0);
    chk("R11", "lock_q", int'(lock_q), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 1;
    #1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_cfg_write();
    t_lock();
    t_sw_unlocked();
    t_sw_locked();
    t_same_cycle();
    t_order();
    t_hw_mid();
    do_hw_reset();
    t_reset();
    done = 1;
    finish_run();
  end
endmodule